// File: doc/BRIEF.md
# Floppy Drive Host Register Port

This block is the host-facing register port of a 3.5-inch floppy drive. The host places a 4-bit address on its address lines. The block returns one bit on its read output, picked from sixteen one-bit sources. Eight sources are flags that the host itself writes. Four are status inputs from the drive logic, such as disk present, write protect and head at track zero. Three are live signals, such as the data bit under the head and the motor tachometer. One is a constant. A parameter table in the top module sets which address returns which source.

The read path is a plain combinational select, so the read bit follows the address lines and the selected source with no clock in between. The same address lines also carry writes. While the host raises the write strobe, the top address bit is the data and the low three bits pick one of the eight flags. The strobe and the address are brought into the system clock through a two-flop synchroniser. One write is taken on each detected rising edge, and a one-cycle pulse with the index and value tells the drive-control logic to act on it, for example to step or eject. When the drive is not selected, the read output is released and writes are dropped.

Top module: `flpy_regif`

## Requirements
- R1: `rd_bit` is a combinational function of `addr_in` and the sources. A change of `addr_in` shows on `rd_bit` without any clock edge.
- R2: With the address held, a change of the selected status or live input shows on `rd_bit` without any clock edge.
- R3: A write sets the stored flag at index `addr_in[2:0]` to `addr_in[3]`. That flag is then read back at address equal to its index (addresses 0 to 7 in the default table).
- R4: With the default table, addresses 8 to 11 return `status_in[0]` to `status_in[3]`, addresses 12 to 14 return `live_in[0]` to `live_in[2]`, and address 15 returns constant 1. Each table entry is 5 bits: kind in bits 4:3 (0 stored, 1 status, 2 live, 3 constant) and selector in bits 2:0.
- R5: If `wstrb_in` is driven high before clock edge E1, `wr_pulse` is high for exactly the one cycle after edge E3. During that cycle `wr_idx` equals the written index and `wr_val` the written bit.
- R6: Holding `wstrb_in` high for many cycles gives only one write and one pulse.
- R7: While `drive_sel` is low, `rd_oe` and `rd_bit` are 0. A write strobe seen while the drive is deselected produces no pulse and leaves every stored flag unchanged.
- R8: Synchronous reset clears all stored flags to 0 and holds `wr_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| drive_sel | input | 1 | Drive selected, in the clock domain |
| addr_in | input | 4 | Host address; during a write, bit 3 is data and bits 2:0 the index |
| wstrb_in | input | 1 | Host write strobe, asynchronous |
| status_in | input | 4 | Status flags from the drive logic |
| live_in | input | 3 | Live signals (read data, tachometer, spare) |
| rd_bit | output | 1 | Selected read bit |
| rd_oe | output | 1 | Read output enable (low = released) |
| wr_pulse | output | 1 | One-cycle strobe for each accepted write |
| wr_idx | output | 3 | Index of the accepted write |
| wr_val | output | 1 | Value of the accepted write |

## Verification
The read results have no latency. The bench changes the address or a source between clock edges and samples `rd_bit` 1 ns later, before any edge occurs. The write results come from three registers in a row: two synchroniser flops and the pulse register. So the bench raises the strobe on a falling edge, expects nothing after the first two rising edges, and expects the pulse 1 ns after the third rising edge and no longer after the fourth. Readback of stored flags and the effects of deselect and reset are checked only after the strobe has dropped and the synchroniser has settled.

// File: rtl/flpy_regif_pkg.sv
package flpy_regif_pkg;

    localparam int ADDR_W     = 4;
    localparam int NUM_ENT    = 1 << ADDR_W;
    localparam int IDX_W      = ADDR_W - 1;
    localparam int NUM_STORED = 1 << IDX_W;
    localparam int SEL_W      = 3;
    localparam int ENT_W      = 2 + SEL_W;
    localparam int MAP_W      = NUM_ENT * ENT_W;

    typedef enum logic [1:0] {
        SRC_STORED = 2'd0,
        SRC_STATUS = 2'd1,
        SRC_LIVE   = 2'd2,
        SRC_CONST  = 2'd3
    } src_kind_e;

    typedef struct packed {
        src_kind_e          kind;
        logic [SEL_W-1:0]   sel;
    } src_ent_t;

    typedef struct packed {
        logic [IDX_W-1:0]   idx;
        logic               val;
    } wr_cmd_t;

    function automatic src_ent_t make_ent(src_kind_e k, int s);
        src_ent_t e;
        e.kind = k;
        e.sel  = SEL_W'(s);
        return e;
    endfunction

    // Default table: 0-7 stored flags, 8-11 status, 12-14 live, 15 constant one
    function automatic logic [MAP_W-1:0] default_map();
        logic [MAP_W-1:0] m;
        m = '0;
        for (int a = 0; a < NUM_ENT; a++) begin
            src_ent_t e;
            if (a < 8)       e = make_ent(SRC_STORED, a);
            else if (a < 12) e = make_ent(SRC_STATUS, a - 8);
            else if (a < 15) e = make_ent(SRC_LIVE, a - 12);
            else             e = make_ent(SRC_CONST, 1);
            m[a*ENT_W +: ENT_W] = e;
        end
        return m;
    endfunction

    function automatic src_ent_t ent_at(logic [MAP_W-1:0] m, int a);
        return src_ent_t'(m[a*ENT_W +: ENT_W]);
    endfunction

endpackage

// File: rtl/flpy_sync.sv
module flpy_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/flpy_wr_capture.sv
module flpy_wr_capture
    import flpy_regif_pkg::*;
#(
    parameter logic [NUM_STORED-1:0] RST_FLAGS = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wstrb_s,
    input  logic [ADDR_W-1:0]     addr_s,
    input  logic                  drive_sel,
    output logic [NUM_STORED-1:0] flags,
    output logic                  wr_pulse,
    output wr_cmd_t               wr_cmd
);

    logic    wstrb_q;
    logic    take;
    wr_cmd_t cmd_now;

    always_comb begin
        cmd_now.idx = addr_s[IDX_W-1:0];
        cmd_now.val = addr_s[ADDR_W-1];
        take        = wstrb_s & ~wstrb_q & drive_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wstrb_q  <= 1'b0;
            flags    <= RST_FLAGS;
            wr_cmd   <= '0;
            wr_pulse <= 1'b0;
        end else begin
            wstrb_q  <= wstrb_s;
            wr_pulse <= 1'b0;
            if (take) begin
                flags[cmd_now.idx] <= cmd_now.val;
                wr_cmd             <= cmd_now;
                wr_pulse           <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/flpy_rd_select.sv
module flpy_rd_select
    import flpy_regif_pkg::*;
#(
    parameter int               NUM_STATUS = 4,
    parameter int               NUM_LIVE   = 3,
    parameter logic [MAP_W-1:0] SRC_MAP    = default_map()
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NUM_STORED-1:0] flags,
    input  logic [NUM_STATUS-1:0] status_in,
    input  logic [NUM_LIVE-1:0]   live_in,
    input  logic                  drive_sel,
    output logic                  rd_bit,
    output logic                  rd_oe
);

    logic [NUM_ENT-1:0] ent_bit;

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        localparam src_ent_t ENT   = ent_at(SRC_MAP, e);
        localparam int       SEL_I = int'(ENT.sel);
        if (ENT.kind == SRC_STORED) begin : g_stored
            assign ent_bit[e] = flags[SEL_I];
        end else if (ENT.kind == SRC_STATUS && SEL_I < NUM_STATUS) begin : g_status
            assign ent_bit[e] = status_in[SEL_I];
        end else if (ENT.kind == SRC_LIVE && SEL_I < NUM_LIVE) begin : g_live
            assign ent_bit[e] = live_in[SEL_I];
        end else if (ENT.kind == SRC_CONST) begin : g_const
            assign ent_bit[e] = ENT.sel[0];
        end else begin : g_none
            assign ent_bit[e] = 1'b0;
        end
    end

    always_comb begin
        rd_oe  = drive_sel;
        rd_bit = drive_sel & ent_bit[addr];
    end

endmodule

// File: rtl/flpy_regif.sv
module flpy_regif
    import flpy_regif_pkg::*;
#(
    parameter int                    NUM_STATUS = 4,
    parameter int                    NUM_LIVE   = 3,
    parameter int                    SYNC_STG   = 2,
    parameter logic [MAP_W-1:0]      SRC_MAP    = default_map(),
    parameter logic [NUM_STORED-1:0] RST_FLAGS  = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  drive_sel,
    input  logic [ADDR_W-1:0]     addr_in,
    input  logic                  wstrb_in,
    input  logic [NUM_STATUS-1:0] status_in,
    input  logic [NUM_LIVE-1:0]   live_in,
    output logic                  rd_bit,
    output logic                  rd_oe,
    output logic                  wr_pulse,
    output logic [IDX_W-1:0]      wr_idx,
    output logic                  wr_val
);

    localparam int SYNC_W = ADDR_W + 1;

    logic [SYNC_W-1:0]     sync_q;
    logic [NUM_STORED-1:0] flags;
    wr_cmd_t               wr_cmd;

    flpy_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({wstrb_in, addr_in}),
        .q   (sync_q)
    );

    flpy_wr_capture #(
        .RST_FLAGS (RST_FLAGS)
    ) u_wr (
        .clk       (clk),
        .rst       (rst),
        .wstrb_s   (sync_q[SYNC_W-1]),
        .addr_s    (sync_q[ADDR_W-1:0]),
        .drive_sel (drive_sel),
        .flags     (flags),
        .wr_pulse  (wr_pulse),
        .wr_cmd    (wr_cmd)
    );

    flpy_rd_select #(
        .NUM_STATUS (NUM_STATUS),
        .NUM_LIVE   (NUM_LIVE),
        .SRC_MAP    (SRC_MAP)
    ) u_rd (
        .addr      (addr_in),
        .flags     (flags),
        .status_in (status_in),
        .live_in   (live_in),
        .drive_sel (drive_sel),
        .rd_bit    (rd_bit),
        .rd_oe     (rd_oe)
    );

    assign wr_idx = wr_cmd.idx;
    assign wr_val = wr_cmd.val;

endmodule

// File: rtl/flpy_regif_chk.sv
module flpy_regif_chk #(
    parameter int NUM_STATUS = 4,
    parameter int NUM_LIVE   = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  drive_sel,
    input logic [3:0]            addr_in,
    input logic                  wstrb_in,
    input logic [NUM_STATUS-1:0] status_in,
    input logic [NUM_LIVE-1:0]   live_in,
    input logic                  rd_bit,
    input logic                  rd_oe,
    input logic                  wr_pulse,
    input logic [2:0]            wr_idx,
    input logic                  wr_val
);

    a_r7_released: assert property (@(posedge clk) disable iff (rst)
        !drive_sel |-> (!rd_oe && !rd_bit));

    a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);

    a_r5_pulse_origin: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> ($past(wstrb_in, 3) && wr_idx == $past(addr_in[2:0], 3)
                      && wr_val == $past(addr_in[3], 3)));

    a_r7_no_write_idle: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> $past(drive_sel));

endmodule

bind flpy_regif flpy_regif_chk #(
    .NUM_STATUS (NUM_STATUS),
    .NUM_LIVE   (NUM_LIVE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .drive_sel (drive_sel),
    .addr_in   (addr_in),
    .wstrb_in  (wstrb_in),
    .status_in (status_in),
    .live_in   (live_in),
    .rd_bit    (rd_bit),
    .rd_oe     (rd_oe),
    .wr_pulse  (wr_pulse),
    .wr_idx    (wr_idx),
    .wr_val    (wr_val)
);

// File: tb/flpy_regif_tb.sv
`timescale 1ns/1ps
module flpy_regif_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       drive_sel = 1'b1;
    logic [3:0] addr_in = '0;
    logic       wstrb_in = 1'b0;
    logic [3:0] status_in = '0;
    logic [2:0] live_in = '0;
    logic       rd_bit, rd_oe, wr_pulse, wr_val;
    logic [2:0] wr_idx;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic [7:0] exp_flags = '0;

    always #2.5 clk = ~clk;

    flpy_regif u_dut (
        .clk(clk), .rst(rst), .drive_sel(drive_sel), .addr_in(addr_in),
        .wstrb_in(wstrb_in), .status_in(status_in), .live_in(live_in),
        .rd_bit(rd_bit), .rd_oe(rd_oe), .wr_pulse(wr_pulse),
        .wr_idx(wr_idx), .wr_val(wr_val)
    );

    typedef struct packed {
        logic [3:0] addr;
        logic [3:0] stat;
        logic [2:0] live;
        logic       exp;
    } vec_t;

    // R1 R4: default table, flags all zero after reset
    localparam vec_t VECS [12] = '{
        '{4'd8,  4'b0001, 3'b000, 1'b1},
        '{4'd9,  4'b0001, 3'b000, 1'b0},
        '{4'd11, 4'b1000, 3'b000, 1'b1},
        '{4'd10, 4'b1011, 3'b000, 1'b0},
        '{4'd12, 4'b0000, 3'b001, 1'b1},
        '{4'd13, 4'b0000, 3'b101, 1'b0},
        '{4'd14, 4'b0000, 3'b100, 1'b1},
        '{4'd15, 4'b0000, 3'b000, 1'b1},
        '{4'd3,  4'b1111, 3'b111, 1'b0},
        '{4'd0,  4'b1111, 3'b111, 1'b0},
        '{4'd14, 4'b0000, 3'b011, 1'b0},
        '{4'd9,  4'b0010, 3'b000, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_write(input int idx, input bit val, input int hold, input bit expect_take);
        @(negedge clk);
        addr_in  = {val, 3'(idx)};
        wstrb_in = 1'b1;
        @(posedge clk);
        @(posedge clk); #1;
        chk(wr_pulse == 1'b0, "R5 no pulse before third edge", wr_pulse, 0);
        @(posedge clk); #1;
        if (expect_take) begin
            chk(wr_pulse == 1'b1, "R5 pulse after third edge", wr_pulse, 1);
            chk(wr_idx == 3'(idx) && wr_val == val, "R5 pulse payload",
                {wr_idx, wr_val}, {3'(idx), val});
            exp_flags[idx] = val;
        end else begin
            chk(wr_pulse == 1'b0, "R7 no pulse while deselected", wr_pulse, 0);
        end
        @(posedge clk); #1;
        chk(wr_pulse == 1'b0, "R5 pulse lasts one cycle", wr_pulse, 0);
        for (int h = 0; h < hold; h++) begin
            @(posedge clk); #1;
            chk(wr_pulse == 1'b0, "R6 single write while strobe held", wr_pulse, 0);
        end
        @(negedge clk);
        wstrb_in = 1'b0;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic read_flags(input string req);
        for (int a = 0; a < 8; a++) begin
            addr_in = 4'(a);
            #1;
            chk(rd_bit == exp_flags[a], req, rd_bit, exp_flags[a]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R8: reset state
        chk(wr_pulse == 1'b0, "R8 no pulse after reset", wr_pulse, 0);
        read_flags("R8 flags clear after reset");

        // R1 R4: vector table walk, no clock between steps
        @(negedge clk);
        for (int v = 0; v < 12; v++) begin
            addr_in   = VECS[v].addr;
            status_in = VECS[v].stat;
            live_in   = VECS[v].live;
            #0.5;
            chk(rd_bit == VECS[v].exp, "R1 R4 table read", rd_bit, VECS[v].exp);
        end

        // R2: source change with address held
        @(negedge clk);
        addr_in = 4'd12; live_in = 3'b000; #0.5;
        chk(rd_bit == 1'b0, "R2 live low", rd_bit, 0);
        live_in[0] = 1'b1; #0.5;
        chk(rd_bit == 1'b1, "R2 live rise follows", rd_bit, 1);
        live_in[0] = 1'b0; #0.5;
        chk(rd_bit == 1'b0, "R2 live fall follows", rd_bit, 0);
        addr_in = 4'd10; status_in[2] = 1'b1; #0.5;
        chk(rd_bit == 1'b1, "R2 status change follows", rd_bit, 1);

        // R3 R5 R6: writes and readback
        do_write(5, 1'b1, 30, 1'b1);
        do_write(0, 1'b1, 2, 1'b1);
        do_write(7, 1'b1, 2, 1'b1);
        read_flags("R3 readback after writes");
        do_write(5, 1'b0, 2, 1'b1);
        read_flags("R3 readback after clear");

        // R7: deselected drive
        @(negedge clk);
        drive_sel = 1'b0;
        addr_in = 4'd15; #1;
        chk(rd_oe == 1'b0 && rd_bit == 1'b0, "R7 output released", {rd_oe, rd_bit}, 0);
        do_write(2, 1'b1, 2, 1'b0);
        drive_sel = 1'b1;
        #1;
        read_flags("R7 deselected write ignored");

        // R8: mid-run reset clears flags
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_flags = '0;
        #1;
        read_flags("R8 flags clear after second reset");

        done = 1'b1;
        finish_run();
    end

endmodule